// File: doc/BRIEF.md
# Segmented Address Generator with Bit-20 Gate

This block turns a 16-bit segment value and a 16-bit offset into a 21-bit physical address, as a real-mode segmented processor does. It holds four 16-bit segment registers: extra, code, stack and data. For each request it picks one of them from the kind of access, or from an explicit override. It forms the offset from a base value plus a displacement. It then adds the offset to the chosen segment shifted left by four bits.

The final sum can carry out of bit 19. That carry becomes address bit 20, but only while a gate-enable control bit is set. With the gate cleared, bit 20 is forced to zero and addresses wrap inside 1 MiB. With the gate set, a segment near the top of the space reaches just past 1 MiB.

Requests arrive on a valid/ready interface and results leave on one. The output register holds one address. `req_ready` is high whenever that register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is taken. Segment writes and gate writes use plain write strobes.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0, `req_ready` is 1, all four segment registers hold 0 and the gate is disabled.
- R2: A segment write with select 0 loads extra, 1 loads code, 2 loads stack and 3 loads data. A request accepted in the same cycle as the write sees the old value; requests accepted in later cycles see the new one.
- R3: For data accesses the effective offset is (`req_base` + `req_disp`) modulo 2^16, and the carry of that sum is discarded.
- R4: The address is segment×16 + effective offset, computed as a 21-bit sum.
- R5: The gate resets to disabled and is loaded from `gate_wr_data` when `gate_wr_en` is high. While the gate is disabled, bit 20 of every produced address is 0.
- R6: A fetch (`req_fetch`=1) uses the code segment with `req_base` as the offset. `req_disp` and the override inputs have no effect on a fetch.
- R7: A data access with no override uses the stack segment when `req_base_kind` is 1 (stack pointer) or 2 (base pointer), and the data segment when it is 0 or 3.
- R8: On a data access with `req_ovr_en`=1, `req_ovr_sel` chooses the segment, using the encoding of R2. This takes priority over the R7 defaults.
- R9: A request accepted at a clock edge makes `out_valid` high with its address after that edge. `out_valid` falls after the next edge that has `out_ready` high and accepts no new request.
- R10: While `out_valid` is 1 and `out_ready` is 0, `req_ready` is 0 and `out_addr` and `out_valid` hold their values.
- R11: With segment 0xFFFF and a nonzero offset that carries past bit 19, the address lands above 1 MiB when the gate is enabled (offset 0x0010 gives 0x100000). When the gate is disabled it wraps to the low megabyte (0x00000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write: 0 extra, 1 code, 2 stack, 3 data |
| seg_wr_data | input | 16 | New segment value |
| gate_wr_en | input | 1 | Gate control write strobe |
| gate_wr_data | input | 1 | New gate enable value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_base_kind | input | 2 | Base register kind: 1 stack pointer, 2 base pointer, 0/3 other |
| req_base | input | 16 | Base register value (instruction pointer on fetch) |
| req_disp | input | 16 | Displacement |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_sel | input | 2 | Override segment, encoded as seg_wr_sel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 21 | Physical address |

## Verification
Each address is due one edge after its request is accepted, so the bench drives on falling edges and reads the result at the next falling edge. Segment and gate writes take effect at the edge that captures them. The bench therefore issues dependent requests one cycle later, except where it deliberately overlaps a write with a request to check the old-value rule. During back-pressure the bench samples across several falling edges to see that the result stays held. It then raises `out_ready` and expects the waiting request to replace the result after a single edge.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_COUNT = 4;
  localparam int SEL_W     = 2;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    BASE_OTHER  = 2'd0,
    BASE_STKPTR = 2'd1,
    BASE_FRMPTR = 2'd2,
    BASE_OTHER2 = 2'd3
  } base_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             gate_wr_en,
  input  logic             gate_wr_data,
  output logic [SEG_W-1:0] segs [SEG_COUNT],
  output logic             gate_en
);
  // one register per segment
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    logic [SEG_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        val_q <= wr_data;
    end
    assign segs[g] = val_q;
  end

  // bit-20 gate control, disabled out of reset
  logic gate_q;
  always_ff @(posedge clk) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else if (gate_wr_en)
      gate_q <= gate_wr_data;
  end
  assign gate_en = gate_q;
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             fetch,
  input  logic [1:0]       base_kind,
  input  logic             ovr_en,
  input  logic [SEL_W-1:0] ovr_sel,
  input  logic [SEG_W-1:0] segs [SEG_COUNT],
  output logic [SEG_W-1:0] seg_val
);
  logic [SEL_W-1:0] pick;

  // fetch > override > stack-relative base > data default
  always_comb begin
    if (fetch)
      pick = SEG_CODE;
    else if (ovr_en)
      pick = ovr_sel;
    else if (base_kind == BASE_STKPTR || base_kind == BASE_FRMPTR)
      pick = SEG_STACK;
    else
      pick = SEG_DATA;
  end

  assign seg_val = segs[pick];
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = OFF_W + SHIFT + 1
) (
  input  logic              fetch,
  input  logic [OFF_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  base,
  input  logic [OFF_W-1:0]  disp,
  input  logic              gate_en,
  output logic [ADDR_W-1:0] addr
);
  logic [OFF_W-1:0]  eff;
  logic [ADDR_W-1:0] sum;

  // offset wraps at 2^OFF_W; a fetch uses the pointer unchanged
  assign eff = fetch ? base : (base + disp);

  assign sum = {1'b0, seg_val, {SHIFT{1'b0}}} + {{(SHIFT + 1){1'b0}}, eff};

  // carry out of the top bit of the window passes only through the gate
  assign addr = {sum[ADDR_W-1] & gate_en, sum[ADDR_W-2:0]};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_wr_en,
  input  logic [1:0]             seg_wr_sel,
  input  logic [OFF_W-1:0]       seg_wr_data,
  input  logic                   gate_wr_en,
  input  logic                   gate_wr_data,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_fetch,
  input  logic [1:0]             req_base_kind,
  input  logic [OFF_W-1:0]       req_base,
  input  logic [OFF_W-1:0]       req_disp,
  input  logic                   req_ovr_en,
  input  logic [1:0]             req_ovr_sel,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OFF_W+SHIFT:0]   out_addr
);
  localparam int ADDR_W = OFF_W + SHIFT + 1;

  logic [OFF_W-1:0]  segs [SEG_COUNT];
  logic              gate_en;
  logic [OFF_W-1:0]  seg_val;
  logic [ADDR_W-1:0] addr_d;
  logic              accept;

  seg_regfile #(.SEG_W(OFF_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (seg_wr_en),
    .wr_sel       (seg_wr_sel),
    .wr_data      (seg_wr_data),
    .gate_wr_en   (gate_wr_en),
    .gate_wr_data (gate_wr_data),
    .segs         (segs),
    .gate_en      (gate_en)
  );

  seg_select #(.SEG_W(OFF_W)) u_sel (
    .fetch     (req_fetch),
    .base_kind (req_base_kind),
    .ovr_en    (req_ovr_en),
    .ovr_sel   (req_ovr_sel),
    .segs      (segs),
    .seg_val   (seg_val)
  );

  seg_addr_calc #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_calc (
    .fetch   (req_fetch),
    .seg_val (seg_val),
    .base    (req_base),
    .disp    (req_disp),
    .gate_en (gate_en),
    .addr    (addr_d)
  );

  // single output stage: free when empty or draining this cycle
  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= addr_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_fetch,
  input logic [OFF_W-1:0]   req_base,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OFF_W+SHIFT:0] out_addr,
  input logic               gate_en
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R9: an accepted request yields a valid result next cycle
  p_valid_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9: no result appears or lingers without a request
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && (!out_valid || out_ready)) |=> !out_valid);

  // R10: stalled output blocks the request side
  p_stall_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  // R10: stalled output holds its address
  p_stall_holds_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R5: gate off means no address above the low megabyte
  p_gate_off_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !gate_en) |=> !out_addr[OFF_W+SHIFT]);

  // R6: fetch offset low nibble passes straight to the address
  p_fetch_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_fetch) |=> (out_addr[SHIFT-1:0] == $past(req_base[SHIFT-1:0])));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_fetch (req_fetch),
  .req_base  (req_base),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .gate_en   (gate_en)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        gate_wr_en = 1'b0;
  logic        gate_wr_data = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_fetch = 1'b0;
  logic [1:0]  req_base_kind = '0;
  logic [15:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic        req_ovr_en = 1'b0;
  logic [1:0]  req_ovr_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [20:0] out_addr;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (.*);

  // segment values by id: 0 extra, 1 code, 2 stack, 3 data
  logic [15:0] segv [4] = '{16'h1234, 16'hF000, 16'h8001, 16'h0FFF};

  localparam int NV = 10;
  localparam logic        V_FETCH [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic [1:0]  V_KIND  [NV] = '{0, 1, 0, 1, 2, 3, 1, 0, 2, 0};
  localparam logic        V_OEN   [NV] = '{0, 1, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam logic [1:0]  V_OSEL  [NV] = '{0, 3, 0, 0, 0, 0, 0, 1, 3, 2};
  localparam logic [15:0] V_BASE  [NV] = '{16'h0100, 16'hFFFF, 16'h1000, 16'hFFF0, 16'h0004,
                                           16'h7FFF, 16'h0010, 16'h0002, 16'h0100, 16'hABCD};
  localparam logic [15:0] V_DISP  [NV] = '{16'h5555, 16'h0001, 16'h0020, 16'h0020, 16'h0004,
                                           16'h0001, 16'h0000, 16'h0003, 16'hFF00, 16'h1111};
  localparam logic [1:0]  V_SEG   [NV] = '{1, 1, 3, 2, 2, 3, 0, 1, 3, 2};
  localparam string       V_REQ   [NV] = '{"R6", "R6", "R7", "R3", "R7",
                                           "R7", "R8", "R8", "R3", "R8"};

  function automatic logic [20:0] model(input logic [15:0] seg, input logic [15:0] off,
                                        input logic gate);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    if (!gate) s[20] = 1'b0;
    return s;
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic seg_write(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic gate_write(input logic v);
    @(negedge clk);
    gate_wr_en = 1'b1; gate_wr_data = v;
    @(negedge clk);
    gate_wr_en = 1'b0;
  endtask

  task automatic drive(input logic f, input logic [1:0] k, input logic oe,
                       input logic [1:0] os, input logic [15:0] b, input logic [15:0] d);
    req_fetch = f; req_base_kind = k; req_ovr_en = oe;
    req_ovr_sel = os; req_base = b; req_disp = d;
  endtask

  // request held for one edge; result read at the following falling edge
  task automatic issue(input logic f, input logic [1:0] k, input logic oe,
                       input logic [1:0] os, input logic [15:0] b, input logic [15:0] d);
    @(negedge clk);
    drive(f, k, oe, os, b, d);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", {20'h0, out_valid}, 21'h0);
    check("R1", {20'h0, req_ready}, 21'h1);
    // R1: segments zero, gate off
    issue(0, 0, 0, 0, 16'h1234, 16'h0000);
    check("R1", out_addr, 21'h01234);
    // R9: valid only one cycle with out_ready high
    @(negedge clk);
    check("R9", {20'h0, out_valid}, 21'h0);

    // R2: load every segment through the encoded select
    for (int s = 0; s < 4; s++) seg_write(2'(s), segv[s]);
    gate_write(1'b1);

    // table walk: R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [15:0] off;
      off = V_FETCH[i] ? V_BASE[i] : (V_BASE[i] + V_DISP[i]);
      issue(V_FETCH[i], V_KIND[i], V_OEN[i], V_OSEL[i], V_BASE[i], V_DISP[i]);
      check("R9", {20'h0, out_valid}, 21'h1);
      check(V_REQ[i], out_addr, model(segv[V_SEG[i]], off, 1'b1));
    end

    // R11 / R4: segment FFFF, carry past bit 19
    seg_write(2'd3, 16'hFFFF);
    issue(0, 0, 0, 0, 16'h0008, 16'h0008);
    check("R11", out_addr, 21'h100000);
    issue(0, 0, 0, 0, 16'hFFFF, 16'h0000);
    check("R4", out_addr, 21'h10FFEF);
    gate_write(1'b0);
    issue(0, 0, 0, 0, 16'h0008, 16'h0008);
    check("R11", out_addr, 21'h000000);
    issue(0, 0, 0, 0, 16'hFFFF, 16'h0000);
    check("R5", out_addr, 21'h00FFEF);

    // R2: write and request in one cycle sees the old value
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h2222;
    drive(0, 0, 0, 0, 16'h0000, 16'h0000);
    req_valid = 1'b1;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    check("R2", out_addr, 21'h0FFFF0);
    issue(0, 0, 0, 0, 16'h0000, 16'h0000);
    check("R2", out_addr, 21'h022220);

    // R10: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(0, 0, 0, 0, 16'h0001, 16'h0000);
    req_valid = 1'b1;
    @(negedge clk);
    drive(0, 0, 0, 0, 16'h0002, 16'h0000);
    check("R10", out_addr, 21'h022221);
    check("R10", {20'h0, req_ready}, 21'h0);
    @(negedge clk);
    check("R10", out_addr, 21'h022221);
    check("R10", {20'h0, out_valid}, 21'h1);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", out_addr, 21'h022222);
    check("R10", {20'h0, out_valid}, 21'h1);
    @(negedge clk);
    check("R9", {20'h0, out_valid}, 21'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule